// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block drives a chain of single-wire addressable RGB LEDs. It keeps a small pixel buffer indexed by LED position. A host writes 24-bit colours into the buffer at any time, sets how many LEDs the chain holds, and then pulses an update strobe. Only the update puts buffer contents on the wire.

During an update the driver walks the buffer from index 0 up to the chain length minus one. It sends each colour as 24 pulse-width coded bits. The width of the high part of each bit period carries the bit value. After the last pixel the line stays low for a latch gap, which makes the LEDs take up their new colours. A busy flag covers the whole frame, latch gap included. All pulse widths are counted in system clocks and derived from a clock-frequency parameter.

Top module: `led_chain_driver`

## Requirements
- R1: After reset, busy and the serial output are 0, the chain length is MAX_LEDS, and every buffer entry is 0x000000.
- R2: Every bit lasts BIT_CYC = CLK_HZ/800000 clocks. A 0 bit is high for CLK_HZ*7/20000000 clocks and a 1 bit is high for CLK_HZ*7/10000000 clocks (integer division). The line is low for the rest of the bit.
- R3: A colour is written as 0xRRGGBB. On the wire each pixel goes out as green byte, then red byte, then blue byte, each most significant bit first. Pixels go out in index order starting at 0.
- R4: An update accepted while idle sends exactly chain-length pixels and then holds the line low for LATCH_CYC = CLK_HZ/20000 clocks. Busy is high for exactly length*24*BIT_CYC + LATCH_CYC clocks, starting the cycle after the strobe is sampled.
- R5: Pixel writes only change the buffer. With no update, the output stays low and busy stays 0.
- R6: An update strobe that arrives while busy is ignored. It neither restarts nor extends the frame.
- R7: A pixel write whose index is at or above the current chain length is discarded, and the stored value at that index is kept.
- R8: A length write while busy is ignored. A length above MAX_LEDS is stored as MAX_LEDS. A length of 0 makes an update send only the latch gap.
- R9: The serial output is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_we | input | 1 | Pixel write enable |
| pix_idx | input | IDXW | LED index of the pixel write |
| pix_rgb | input | 24 | Colour as 0xRRGGBB |
| len_we | input | 1 | Chain length write enable |
| len_val | input | IDXW+1 | New chain length |
| upd_req | input | 1 | Update strobe: send the buffer to the chain |
| busy | output | 1 | High from the accepted update to the end of the latch gap |
| led_dout | output | 1 | Serial pulse-width coded data to the chain |

## Verification
Three cases are the hardest to reach from the ports: a second update strobe and a length write that land in the middle of a running frame, and a pixel write whose stored value is hidden behind a short chain. The stimulus starts a three-LED frame and fires both the strobe and a length write of seven partway through. A following frame then shows that the length is still three and that the busy window ran exactly once. For the hidden write, the chain is first shortened and an out-of-range index is written. The chain is then lengthened again, so the update reveals the stored value that had to survive.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] grn;
        logic [7:0] blu;
    } rgb_t;

    function automatic logic [23:0] wire_order(input rgb_t c);
        return {c.grn, c.red, c.blu};
    endfunction

    function automatic int bit_cycles(input int hz);
        return hz / 800000;
    endfunction

    function automatic int zero_high(input int hz);
        return int'((longint'(hz) * 7) / 20000000);
    endfunction

    function automatic int one_high(input int hz);
        return int'((longint'(hz) * 7) / 10000000);
    endfunction

    function automatic int latch_cycles(input int hz);
        return hz / 20000;
    endfunction

endpackage

// File: rtl/led_pixel_store.sv
module led_pixel_store
    import led_chain_pkg::*;
#(
    parameter int MAX_LEDS = 16,
    parameter int IDXW     = 4,
    parameter int CNTW     = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  rgb_t            wr_rgb,
    input  logic            len_we,
    input  logic [CNTW-1:0] len_val,
    input  logic            lock,
    input  logic [IDXW-1:0] rd_idx,
    output rgb_t            rd_rgb,
    output logic [CNTW-1:0] chain_len
);
    localparam logic [CNTW-1:0] LEN_MAX = CNTW'(MAX_LEDS);

    rgb_t pix_mem [MAX_LEDS];

    // Length register: frozen while a frame runs, saturates at MAX_LEDS
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_len <= LEN_MAX;
        end else if (len_we && !lock) begin
            chain_len <= (len_val > LEN_MAX) ? LEN_MAX : len_val;
        end
    end

    // Buffer: writes beyond the current chain are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_LEDS; i++) pix_mem[i] <= '0;
        end else if (wr_en && ({1'b0, wr_idx} < chain_len)) begin
            pix_mem[wr_idx] <= wr_rgb;
        end
    end

    assign rd_rgb = pix_mem[rd_idx];

endmodule

// File: rtl/led_frame_engine.sv
module led_frame_engine
    import led_chain_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int IDXW   = 4,
    parameter int CNTW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CNTW-1:0] chain_len,
    input  rgb_t            pix_rgb,
    output logic [IDXW-1:0] rd_idx,
    output logic            busy,
    output logic            dout
);
    localparam int BIT_CYC = bit_cycles(CLK_HZ);
    localparam int T0H_CYC = zero_high(CLK_HZ);
    localparam int T1H_CYC = one_high(CLK_HZ);
    localparam int LAT_CYC = latch_cycles(CLK_HZ);
    localparam int CYC_TOP = (BIT_CYC > LAT_CYC) ? BIT_CYC : LAT_CYC;
    localparam int CYCW    = $clog2(CYC_TOP + 1);

    eng_state_e      state;
    logic [IDXW-1:0] pix_ptr;
    logic [4:0]      bit_ptr;
    logic [CYCW-1:0] cyc;
    logic [23:0]     shreg;
    logic [CYCW-1:0] hi_lim;
    logic            last_pix;

    assign last_pix = ({1'b0, pix_ptr} == (chain_len - CNTW'(1)));
    assign rd_idx   = (state == ST_SHIFT) ? pix_ptr + IDXW'(1) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pix_ptr <= '0;
            bit_ptr <= '0;
            cyc     <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cyc     <= '0;
                    bit_ptr <= '0;
                    pix_ptr <= '0;
                    if (start) begin
                        if (chain_len == '0) begin
                            state <= ST_LATCH;
                        end else begin
                            state <= ST_SHIFT;
                            shreg <= wire_order(pix_rgb);
                        end
                    end
                end
                ST_SHIFT: begin
                    if (cyc == CYCW'(BIT_CYC - 1)) begin
                        cyc <= '0;
                        if (bit_ptr == 5'd23) begin
                            bit_ptr <= '0;
                            if (last_pix) begin
                                state   <= ST_LATCH;
                                pix_ptr <= '0;
                                shreg   <= '0;
                            end else begin
                                pix_ptr <= pix_ptr + IDXW'(1);
                                shreg   <= wire_order(pix_rgb);
                            end
                        end else begin
                            bit_ptr <= bit_ptr + 5'd1;
                            shreg   <= {shreg[22:0], 1'b0};
                        end
                    end else begin
                        cyc <= cyc + CYCW'(1);
                    end
                end
                ST_LATCH: begin
                    if (cyc == CYCW'(LAT_CYC - 1)) begin
                        cyc   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cyc <= cyc + CYCW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign hi_lim = shreg[23] ? CYCW'(T1H_CYC) : CYCW'(T0H_CYC);
    assign busy   = (state != ST_IDLE);
    assign dout   = (state == ST_SHIFT) && (cyc < hi_lim);

endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver
    import led_chain_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int MAX_LEDS = 16,
    parameter int IDXW     = $clog2(MAX_LEDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pix_we,
    input  logic [IDXW-1:0] pix_idx,
    input  logic [23:0]     pix_rgb,
    input  logic            len_we,
    input  logic [IDXW:0]   len_val,
    input  logic            upd_req,
    output logic            busy,
    output logic            led_dout
);
    localparam int CNTW = IDXW + 1;

    logic [CNTW-1:0] chain_len;
    logic [IDXW-1:0] rd_idx;
    rgb_t            rd_rgb;

    led_pixel_store #(
        .MAX_LEDS (MAX_LEDS),
        .IDXW     (IDXW),
        .CNTW     (CNTW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (pix_we),
        .wr_idx    (pix_idx),
        .wr_rgb    (rgb_t'(pix_rgb)),
        .len_we    (len_we),
        .len_val   (len_val),
        .lock      (busy),
        .rd_idx    (rd_idx),
        .rd_rgb    (rd_rgb),
        .chain_len (chain_len)
    );

    led_frame_engine #(
        .CLK_HZ (CLK_HZ),
        .IDXW   (IDXW),
        .CNTW   (CNTW)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (upd_req),
        .chain_len (chain_len),
        .pix_rgb   (rd_rgb),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .dout      (led_dout)
    );

endmodule

// File: rtl/led_chain_checker.sv
module led_chain_checker
    import led_chain_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int CNTW   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            upd_req,
    input logic            busy,
    input logic            led_dout,
    input logic [CNTW-1:0] chain_len
);
    localparam int T1H_CYC = one_high(CLK_HZ);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)           hi_run <= '0;
        else if (led_dout) hi_run <= hi_run + 16'd1;
        else               hi_run <= '0;
    end

    // R1
    post_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !led_dout));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !led_dout);

    // R2
    high_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        led_dout |-> (hi_run < 16'(T1H_CYC)));

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(upd_req));

    // R4
    latch_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(led_dout));

    // R8
    len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(chain_len));

endmodule

bind led_chain_driver led_chain_checker #(
    .CLK_HZ (CLK_HZ),
    .CNTW   (CNTW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_req   (upd_req),
    .busy      (busy),
    .led_dout  (led_dout),
    .chain_len (chain_len)
);

// File: tb/tb_led_chain_driver.sv
module tb_led_chain_driver;
    localparam int HZ   = 20_000_000;
    localparam int MAXL = 16;
    localparam int IDXW = 4;
    localparam int BITC = HZ / 800000;
    localparam int T0   = (HZ * 7) / 20000000;
    localparam int T1   = (HZ * 7) / 10000000;
    localparam int LAT  = HZ / 20000;

    // stimulus table: {chain length, base colour}
    localparam logic [28:0] VEC [6] = '{
        {5'd1,  24'hFF0000}, {5'd3, 24'h00FF00}, {5'd16, 24'h0000FF},
        {5'd5,  24'hA5C30F}, {5'd2, 24'h123456}, {5'd8,  24'h800001}
    };

    logic clk = 0, rst = 1;
    logic pix_we = 0, len_we = 0, upd_req = 0;
    logic [IDXW-1:0] pix_idx = '0;
    logic [23:0] pix_rgb = '0;
    logic [IDXW:0] len_val = '0;
    logic busy, led_dout;

    always #2 clk = ~clk;

    led_chain_driver #(.CLK_HZ(HZ), .MAX_LEDS(MAXL)) dut (
        .clk(clk), .rst(rst), .pix_we(pix_we), .pix_idx(pix_idx),
        .pix_rgb(pix_rgb), .len_we(len_we), .len_val(len_val),
        .upd_req(upd_req), .busy(busy), .led_dout(led_dout)
    );

    int errors = 0, checks = 0;
    logic [23:0] mdl [MAXL];
    int mlen;

    // line monitor
    int hi, lo, last_hi, nbits, badw, badp, bcnt, rises, idle_hi;
    logic pd = 0, pb = 0, frame_done = 0;
    logic cap [MAXL*24];

    always @(negedge clk) begin
        if (busy && !pb) begin
            nbits = 0; badw = 0; badp = 0; hi = 0; lo = 0; bcnt = 0;
            rises++;
        end
        if (busy) begin
            bcnt++;
            if (led_dout && !pd) begin
                if (nbits > 0 && last_hi + lo != BITC) badp++;
                hi = 1; lo = 0;
            end else if (led_dout) begin
                hi++;
            end else if (pd) begin
                if (nbits < MAXL*24) cap[nbits] = (hi == T1);
                if (hi != T1 && hi != T0) badw++;
                nbits++;
                last_hi = hi; lo = 1;
            end else begin
                lo++;
            end
        end else if (led_dout) begin
            idle_hi++;
        end
        if (!busy && pb) frame_done = 1;
        pd = led_dout; pb = busy;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_pix(input int idx, input logic [23:0] c);
        @(negedge clk); pix_we = 1; pix_idx = IDXW'(idx); pix_rgb = c;
        @(negedge clk); pix_we = 0;
        if (idx < mlen) mdl[idx] = c;
    endtask

    task automatic set_len(input int v);
        @(negedge clk); len_we = 1; len_val = (IDXW+1)'(v);
        @(negedge clk); len_we = 0;
        mlen = (v > MAXL) ? MAXL : v;
    endtask

    task automatic start_frame();
        frame_done = 0;
        @(negedge clk); upd_req = 1;
        @(negedge clk); upd_req = 0;
    endtask

    task automatic finish_frame(input string req);
        int mism;
        logic [23:0] w;
        while (!frame_done) @(negedge clk);
        chk(nbits == mlen*24, {req, " bit count"}, nbits, mlen*24);
        chk(badw == 0, "R2 high width", badw, 0);
        chk(badp == 0, "R2 bit period", badp, 0);
        chk(bcnt == mlen*24*BITC + LAT, "R4 busy length", bcnt, mlen*24*BITC + LAT);
        if (mlen > 0) chk(lo == BITC - last_hi + LAT, "R4 latch gap", lo, BITC - last_hi + LAT);
        else          chk(lo == LAT, "R8 zero-length gap", lo, LAT);
        mism = 0;
        for (int p = 0; p < mlen; p++) begin
            w = {mdl[p][15:8], mdl[p][23:16], mdl[p][7:0]};
            for (int b = 0; b < 24; b++)
                if (p*24 + b < nbits && cap[p*24+b] != w[23-b]) mism++;
        end
        chk(mism == 0, "R3 pixel bits", mism, 0);
    endtask

    initial begin
        #(4 * 190000);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        logic [23:0] c;
        for (int i = 0; i < MAXL; i++) mdl[i] = '0;
        mlen = MAXL;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(led_dout == 0, "R1 output after reset", led_dout, 0);
        // R1: reset length MAX_LEDS, zero buffer
        start_frame(); finish_frame("R1");

        // table-driven frames
        for (int v = 0; v < 6; v++) begin
            set_len(int'(VEC[v][28:24]));
            for (int i = 0; i < mlen; i++) begin
                c = VEC[v][23:0] ^ 24'(i * 24'h0F1E2D);
                wr_pix(i, c);
            end
            start_frame(); finish_frame("R3");
        end

        // R5: writes alone do nothing on the line
        r0 = rises;
        wr_pix(0, 24'h55AA55);
        repeat (200) @(negedge clk);
        chk(rises == r0, "R5 no frame without update", rises, r0);
        chk(busy == 0, "R5 busy stays low", busy, 0);

        // R6 and R8: strobe and length write during busy
        set_len(3);
        r0 = rises;
        start_frame();
        repeat (100) @(negedge clk);
        upd_req = 1; @(negedge clk); upd_req = 0;
        len_we = 1; len_val = 5'd7; @(negedge clk); len_we = 0;
        finish_frame("R6");
        repeat (50) @(negedge clk);
        chk(rises == r0 + 1, "R6 strobe during busy ignored", rises, r0 + 1);
        start_frame(); finish_frame("R8 length kept");

        // R7: out-of-range write is dropped
        set_len(4);
        wr_pix(3, 24'h0F0F0F);
        set_len(2);
        wr_pix(3, 24'hABCDEF);
        wr_pix(15, 24'h111111);
        wr_pix(1, 24'h00C0DE);
        set_len(4);
        start_frame(); finish_frame("R7");

        // R8: saturation and zero length
        set_len(20);
        chk(mlen == MAXL, "R8 model clamp", mlen, MAXL);
        start_frame(); finish_frame("R8 clamp");
        set_len(0);
        start_frame(); finish_frame("R8 zero");

        chk(idle_hi == 0, "R9 output low while idle", idle_hi, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule